// File: doc/BRIEF.md
# Sector Protection Pulse Sequencer

This block is a host-side controller that runs the pulse-and-verify loop used to lock flash sectors against writes. When it receives a start strobe, it requests the high-voltage level on the flash reset line and waits for that level to settle. It then walks a list of sector addresses. For each sector it sends protect pulses and verify reads over a simple request/acknowledge bus until the sector reports itself protected. If a sector still reports unprotected after the allowed number of pulses, the run stops. At the end it withdraws the high voltage, writes a read/reset command and reports done, plus fail if a sector did not lock.

The bus agent on the far side turns each request into real pin timing. The same agent also owns voltage generation. The sequencer only decides which cycles to issue and how long to wait between them. All waits come from nanosecond parameters, converted to clock cycles at elaboration time using a clock-frequency parameter.

Top module: `prot_pulse_seq`

## Requirements
- R1: After reset, busy, done, fail, hv_req and bus_req are all low, and they stay that way until a start strobe arrives.
- R2: An accepted start raises hv_req. No bus request is made until at least the settle wait (SETTLE_NS converted to clock cycles, rounded up) has passed since hv_req rose.
- R3: The first bus cycle of a run is a write of 60h to address 0, issued while hv_req is high.
- R4: A protect pulse is a write of 60h issued while hv_req is high. Its address has the sector number in the top SECT_W bits, bit 1 set, and every other bit clear. In word-address terms, bits 6, 1 and 0 read 0, 1, 0.
- R5: After each protect pulse is acknowledged, the bus stays idle for at least the pulse wait (PULSE_NS in cycles). The block then writes 40h to the same address and reads that address back.
- R6: A read value of exactly 0001h marks the sector protected. Any other value, including 0000h and 0003h, causes another pulse on the same sector.
- R7: Each sector gets at most MAX_PULSES protect pulses. When the verify after the last allowed pulse still fails, the run ends in failure and no further sector is touched.
- R8: Every run ends the same way, whether it succeeds or fails. hv_req drops first, and then a write of F0h to address 0 is issued while hv_req is low.
- R9: At the end of a run, done goes high, and fail goes high only if a sector failed. Both hold until the next accepted start, which clears them.
- R10: A start strobe that arrives while busy is high has no effect on the bus sequence or on the outcome.
- R11: Sectors are handled in list order, entry 0 first. A count of n handles entries 0 to n-1. A count of 0 behaves like a count of 1. The pulse count restarts for each new sector.
- R12: Once raised, a bus request keeps its address, data and direction unchanged until bus_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle strobe that begins a run when idle |
| sect_list | input | NUM_SECT*SECT_W | Packed sector numbers, entry g at bits g*SECT_W upward |
| sect_cnt | input | $clog2(NUM_SECT+1) | Number of list entries to handle |
| hv_req | output | 1 | Request for the high-voltage level on the flash reset line |
| bus_req | output | 1 | Bus cycle request, held until acknowledged |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | ADDR_W | Word address of the bus cycle |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Bus cycle complete; read data valid in the same cycle |
| bus_rdata | input | DATA_W | Read data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished |
| fail | output | 1 | Last run ended with a sector that would not lock |

## Verification
The state machine reveals itself only through the order and content of the bus cycles, so the bench treats every acknowledged cycle as a scoreboard item. A corrupted state or pulse counter therefore shows up at the very next acknowledge, as a wrong address, a wrong command byte, the wrong hv_req level or an unexpected extra cycle. A timer that expires early shows up one cycle later, as a request that arrives before the measured settle or pulse gap. A retry limit that is wrong by one shows up only at the end of a failing sector: one protect round too many or too few appears in front of the reset command.

// File: rtl/prot_seq_pkg.sv
package prot_seq_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_SETUP,
      ST_PULSE,
      ST_PWAIT,
      ST_VCMD,
      ST_VREAD,
      ST_CHECK,
      ST_RELEASE,
      ST_RESET
   } seq_state_t;

   localparam logic [7:0] CMD_PROTECT    = 8'h60;
   localparam logic [7:0] CMD_VERIFY     = 8'h40;
   localparam logic [7:0] CMD_READ_RESET = 8'hF0;
   localparam logic [7:0] VERIFY_LOCKED  = 8'h01;

   // low address pattern that selects the protection path (bit1 high)
   localparam int unsigned CTRL_PATTERN = 32'h0000_0002;

   function automatic longint unsigned ns_to_cycles(input longint unsigned hz,
                                                    input longint unsigned ns);
      return (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
   endfunction

   function automatic longint unsigned max3(input longint unsigned a,
                                            input longint unsigned b,
                                            input longint unsigned c);
      longint unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/prot_seq_timer.sv
module prot_seq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/prot_seq_sector_sel.sv
module prot_seq_sector_sel #(
   parameter int NUM_SECT = 4,
   parameter int SECT_W   = 7,
   parameter int CNT_W    = $clog2(NUM_SECT + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SECT*SECT_W-1:0] sect_list,
   input  logic [CNT_W-1:0]           sect_cnt,
   input  logic                       rewind,
   input  logic                       advance,
   output logic [SECT_W-1:0]          cur_sect,
   output logic                       is_last
);

   localparam int IDX_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;
   localparam int CMP_W = ((CNT_W > IDX_W) ? CNT_W : IDX_W) + 1;

   logic [SECT_W-1:0] entry [NUM_SECT];

   for (genvar g = 0; g < NUM_SECT; g++) begin : g_unpack
      assign entry[g] = sect_list[g*SECT_W +: SECT_W];
   end

   if (NUM_SECT == 1) begin : g_single
      assign cur_sect = entry[0];
      assign is_last  = 1'b1;
   end else begin : g_multi
      logic [IDX_W-1:0] idx_q;
      logic [CMP_W-1:0] nxt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            idx_q <= '0;
         end else if (rewind) begin
            idx_q <= '0;
         end else if (advance && !is_last) begin
            idx_q <= idx_q + IDX_W'(1);
         end
      end

      assign nxt      = CMP_W'(idx_q) + CMP_W'(1);
      assign is_last  = (nxt >= CMP_W'(sect_cnt)) || (nxt >= CMP_W'(NUM_SECT));
      assign cur_sect = entry[idx_q];
   end

endmodule

// File: rtl/prot_seq_bus_cmd.sv
module prot_seq_bus_cmd #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              cmd_we,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   output logic              cmd_done,
   output logic [DATA_W-1:0] rdata_q,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_req   <= 1'b0;
         bus_we    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         rdata_q   <= '0;
      end else if (bus_req && bus_ack) begin
         bus_req <= 1'b0;
         rdata_q <= bus_rdata;
      end else if (issue && !bus_req) begin
         bus_req   <= 1'b1;
         bus_we    <= cmd_we;
         bus_addr  <= cmd_addr;
         bus_wdata <= cmd_data;
      end
   end

   assign cmd_done = bus_req && bus_ack;

   // R12: request fields frozen until acknowledged
   p_req_stable_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                 $stable(bus_wdata) && $stable(bus_we)));

endmodule

// File: rtl/prot_pulse_seq.sv
module prot_pulse_seq
   import prot_seq_pkg::*;
#(
   parameter int          NUM_SECT   = 4,
   parameter int          SECT_W     = 7,
   parameter int          ADDR_W     = 19,
   parameter int          DATA_W     = 16,
   parameter int          MAX_PULSES = 25,
   parameter int unsigned CLK_HZ     = 100_000_000,
   parameter int unsigned SETTLE_NS  = 4_000,
   parameter int unsigned PULSE_NS   = 150_000,
   parameter int unsigned RELEASE_NS = 4_000,
   localparam int         CNT_W      = $clog2(NUM_SECT + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [NUM_SECT*SECT_W-1:0] sect_list,
   input  logic [CNT_W-1:0]           sect_cnt,
   output logic                       hv_req,
   output logic                       bus_req,
   output logic                       bus_we,
   output logic [ADDR_W-1:0]          bus_addr,
   output logic [DATA_W-1:0]          bus_wdata,
   input  logic                       bus_ack,
   input  logic [DATA_W-1:0]          bus_rdata,
   output logic                       busy,
   output logic                       done,
   output logic                       fail
);

   localparam longint unsigned SETTLE_CYC  = ns_to_cycles(CLK_HZ, SETTLE_NS);
   localparam longint unsigned PULSE_CYC   = ns_to_cycles(CLK_HZ, PULSE_NS);
   localparam longint unsigned RELEASE_CYC = ns_to_cycles(CLK_HZ, RELEASE_NS);
   localparam longint unsigned MAX_CYC     = max3(SETTLE_CYC, PULSE_CYC, RELEASE_CYC);
   localparam int              TMR_W       = $clog2(MAX_CYC + 1);
   localparam int              PC_W        = $clog2(MAX_PULSES + 1);

   // elaboration-time parameter checks
   if (NUM_SECT < 1)                 begin : g_bad_nsect  $error("NUM_SECT must be at least 1"); end
   if (MAX_PULSES < 1)               begin : g_bad_pulses $error("MAX_PULSES must be at least 1"); end
   if (SECT_W + 7 > ADDR_W)          begin : g_bad_addr   $error("sector field overlaps control bits"); end
   if (DATA_W < 8)                   begin : g_bad_data   $error("DATA_W must hold a command byte"); end
   if (SETTLE_NS == 0 || PULSE_NS == 0 || RELEASE_NS == 0) begin : g_bad_wait
      $error("wait durations must be nonzero");
   end

   seq_state_t         state_q;
   logic               pend_q;
   logic               hv_q;
   logic               done_q;
   logic               fail_q;
   logic               fail_flag_q;
   logic [PC_W-1:0]    pcnt_q;

   logic               tmr_load;
   logic [TMR_W-1:0]   tmr_val;
   logic               tmr_expired;

   logic               sel_rewind;
   logic               sel_advance;
   logic [SECT_W-1:0]  cur_sect;
   logic               is_last;

   logic               is_cmd_state;
   logic               issue;
   logic               cmd_we;
   logic [ADDR_W-1:0]  cmd_addr;
   logic [DATA_W-1:0]  cmd_data;
   logic               cmd_done;
   logic [DATA_W-1:0]  rdata_q;
   logic [ADDR_W-1:0]  prot_addr;

   logic               accept_start;
   logic               verify_ok;
   logic               retry_left;

   assign accept_start = (state_q == ST_IDLE) && start;
   assign verify_ok    = (rdata_q == DATA_W'(VERIFY_LOCKED));
   assign retry_left   = (pcnt_q != PC_W'(MAX_PULSES));

   assign prot_addr = {cur_sect, {(ADDR_W-SECT_W){1'b0}}} | ADDR_W'(CTRL_PATTERN);

   // ---------------------------------------------------------------- timer
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (accept_start) begin
         tmr_load = 1'b1;
         tmr_val  = TMR_W'(SETTLE_CYC);
      end else if (state_q == ST_PULSE && cmd_done) begin
         tmr_load = 1'b1;
         tmr_val  = TMR_W'(PULSE_CYC);
      end else if (state_q == ST_CHECK &&
                   ((verify_ok && is_last) || (!verify_ok && !retry_left))) begin
         tmr_load = 1'b1;
         tmr_val  = TMR_W'(RELEASE_CYC);
      end
   end

   prot_seq_timer #(.CNT_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   // ------------------------------------------------------- sector walker
   assign sel_rewind  = accept_start;
   assign sel_advance = (state_q == ST_CHECK) && verify_ok && !is_last;

   prot_seq_sector_sel #(
      .NUM_SECT (NUM_SECT),
      .SECT_W   (SECT_W),
      .CNT_W    (CNT_W)
   ) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .sect_list (sect_list),
      .sect_cnt  (sect_cnt),
      .rewind    (sel_rewind),
      .advance   (sel_advance),
      .cur_sect  (cur_sect),
      .is_last   (is_last)
   );

   // ---------------------------------------------------- command selection
   always_comb begin
      is_cmd_state = 1'b1;
      cmd_we       = 1'b1;
      cmd_addr     = '0;
      cmd_data     = '0;
      unique case (state_q)
         ST_SETUP: begin
            cmd_data = DATA_W'(CMD_PROTECT);
         end
         ST_PULSE: begin
            cmd_addr = prot_addr;
            cmd_data = DATA_W'(CMD_PROTECT);
         end
         ST_VCMD: begin
            cmd_addr = prot_addr;
            cmd_data = DATA_W'(CMD_VERIFY);
         end
         ST_VREAD: begin
            cmd_we   = 1'b0;
            cmd_addr = prot_addr;
         end
         ST_RESET: begin
            cmd_data = DATA_W'(CMD_READ_RESET);
         end
         default: begin
            is_cmd_state = 1'b0;
         end
      endcase
   end

   assign issue = is_cmd_state && !pend_q;

   prot_seq_bus_cmd #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue),
      .cmd_we    (cmd_we),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .cmd_done  (cmd_done),
      .rdata_q   (rdata_q),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata)
   );

   // -------------------------------------------------------- sequence FSM
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pend_q      <= 1'b0;
         hv_q        <= 1'b0;
         done_q      <= 1'b0;
         fail_q      <= 1'b0;
         fail_flag_q <= 1'b0;
         pcnt_q      <= '0;
      end else begin
         if (issue) begin
            pend_q <= 1'b1;
         end else if (cmd_done) begin
            pend_q <= 1'b0;
         end

         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q     <= ST_SETTLE;
                  hv_q        <= 1'b1;
                  done_q      <= 1'b0;
                  fail_q      <= 1'b0;
                  fail_flag_q <= 1'b0;
               end
            end
            ST_SETTLE: begin
               if (tmr_expired) state_q <= ST_SETUP;
            end
            ST_SETUP: begin
               if (cmd_done) begin
                  state_q <= ST_PULSE;
                  pcnt_q  <= PC_W'(1);
               end
            end
            ST_PULSE: begin
               if (cmd_done) state_q <= ST_PWAIT;
            end
            ST_PWAIT: begin
               if (tmr_expired) state_q <= ST_VCMD;
            end
            ST_VCMD: begin
               if (cmd_done) state_q <= ST_VREAD;
            end
            ST_VREAD: begin
               if (cmd_done) state_q <= ST_CHECK;
            end
            ST_CHECK: begin
               if (verify_ok) begin
                  if (is_last) begin
                     state_q <= ST_RELEASE;
                     hv_q    <= 1'b0;
                  end else begin
                     state_q <= ST_PULSE;
                     pcnt_q  <= PC_W'(1);
                  end
               end else if (retry_left) begin
                  state_q <= ST_PULSE;
                  pcnt_q  <= pcnt_q + PC_W'(1);
               end else begin
                  state_q     <= ST_RELEASE;
                  hv_q        <= 1'b0;
                  fail_flag_q <= 1'b1;
               end
            end
            ST_RELEASE: begin
               if (tmr_expired) state_q <= ST_RESET;
            end
            ST_RESET: begin
               if (cmd_done) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  fail_q  <= fail_flag_q;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign hv_req = hv_q;
   assign busy   = (state_q != ST_IDLE);
   assign done   = done_q;
   assign fail   = fail_q;

   // ----------------------------------------------------------- assertions
   // R1: nothing is requested while idle
   p_idle_quiet_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bus_req && !hv_req));

   // R2: the cycle after the high voltage is raised, the bus is still quiet
   p_settle_quiet_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hv_req) |=> !bus_req);

   // R4: protect commands are issued only under high voltage
   p_prot_under_hv_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_wdata == DATA_W'(CMD_PROTECT)) |-> hv_req);

   // R5: the bus is idle during the pulse wait
   p_pulse_wait_quiet_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PWAIT) |-> !bus_req);

   // R7: the pulse counter stays within its limit
   p_pcnt_bound_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PWAIT) |-> (pcnt_q >= PC_W'(1) && pcnt_q <= PC_W'(MAX_PULSES)));

   // R8: the reset command is never issued under high voltage
   p_reset_hv_off_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_wdata == DATA_W'(CMD_READ_RESET)) |-> !hv_req);

   // R9: fail is only reported together with done
   p_fail_with_done_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> done);

   // R10: a start while busy never ends the run
   p_busy_start_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !(state_q == ST_RESET && cmd_done)) |=> busy);

endmodule

// File: tb/test_prot_pulse_seq.sv
module test_prot_pulse_seq;

   localparam int NS    = 4;
   localparam int SW    = 7;
   localparam int AW    = 19;
   localparam int DW    = 16;
   localparam int MAXP  = 25;
   localparam int CW    = $clog2(NS + 1);
   // 125 MHz clock: 80 ns -> 10 cycles, 240 ns -> 30 cycles, 40 ns -> 5 cycles
   localparam int SET_C = 10;
   localparam int PUL_C = 30;

   localparam int K_SETUP = 0, K_PULSE = 1, K_VCMD = 2, K_VREAD = 3, K_RESET = 4;

   typedef struct {
      bit            we;
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      bit            hv;
      int            kind;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [NS*SW-1:0]  sect_list = '0;
   logic [CW-1:0]     sect_cnt = '0;
   logic              hv_req, bus_req, bus_we, busy, done, fail;
   logic [AW-1:0]     bus_addr;
   logic [DW-1:0]     bus_wdata;
   logic              bus_ack = 1'b0;
   logic [DW-1:0]     bus_rdata = '0;

   exp_t          exp_q[$];
   logic [DW-1:0] rd_q[$];
   int            checks = 0;
   int            errors = 0;
   longint        cyc = 0;
   longint        t_hv = 0;
   longint        t_pulse = 0;
   bit            hv_prev = 1'b0;
   bit            finished = 1'b0;

   always #4 clk = ~clk;

   prot_pulse_seq #(
      .NUM_SECT   (NS),
      .SECT_W     (SW),
      .ADDR_W     (AW),
      .DATA_W     (DW),
      .MAX_PULSES (MAXP),
      .CLK_HZ     (125_000_000),
      .SETTLE_NS  (80),
      .PULSE_NS   (240),
      .RELEASE_NS (40)
   ) i_prot_pulse_seq (
      .clk, .rst_n, .start, .sect_list, .sect_cnt, .hv_req,
      .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata,
      .busy, .done, .fail
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [AW-1:0] prot_addr(input logic [SW-1:0] s);
      return {s, {(AW-SW){1'b0}}} | AW'(2);
   endfunction

   task automatic push(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit hv, input int kind);
      exp_t e;
      e.we = we; e.addr = a; e.data = d; e.hv = hv; e.kind = kind;
      exp_q.push_back(e);
   endtask

   // one protect/verify round for sector s, with the value the bus will return
   task automatic push_round(input logic [SW-1:0] s, input logic [DW-1:0] rd);
      push(1'b1, prot_addr(s), 16'h0060, 1'b1, K_PULSE);
      push(1'b1, prot_addr(s), 16'h0040, 1'b1, K_VCMD);
      push(1'b0, prot_addr(s), 16'h0000, 1'b1, K_VREAD);
      rd_q.push_back(rd);
   endtask

   task automatic push_sector(input logic [SW-1:0] s, input int nbad, input bit ok_end,
                              input logic [DW-1:0] bad_val);
      for (int j = 0; j < nbad; j++) push_round(s, bad_val);
      if (ok_end) push_round(s, 16'h0001);
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (busy && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic end_run(input string req, input bit exp_fail);
      wait_idle();
      chk(exp_q.size() == 0, req, "expected bus cycles left over", exp_q.size(), 0);
      chk(done == 1'b1, "R9", "done after run", done, 1);
      chk(fail == exp_fail, req, "fail after run", fail, exp_fail);
      chk(hv_req == 1'b0, "R8", "hv_req after run", hv_req, 0);
      exp_q.delete();
      rd_q.delete();
   endtask

   // scoreboard monitor and bus responder
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
      end
   end

   initial begin
      forever begin
         @(negedge clk);
         if (hv_req && !hv_prev) t_hv = cyc;
         hv_prev = hv_req;
         if (bus_ack) begin
            bus_ack = 1'b0;
         end else if (bus_req) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected bus cycle addr", bus_addr, 0);
            end else begin
               exp_t e;
               string tag;
               e = exp_q.pop_front();
               case (e.kind)
                  K_SETUP: tag = "R3";
                  K_PULSE: tag = "R4/R11";
                  K_RESET: tag = "R8";
                  default: tag = "R5";
               endcase
               chk(bus_we == e.we, tag, "direction", bus_we, e.we);
               chk(bus_addr == e.addr, tag, "address", bus_addr, e.addr);
               if (e.we) chk(bus_wdata == e.data, tag, "write data", bus_wdata, e.data);
               chk(hv_req == e.hv, tag, "hv_req level", hv_req, e.hv);
               if (e.kind == K_SETUP)
                  chk(cyc - t_hv >= SET_C, "R2", "settle gap", cyc - t_hv, SET_C);
               if (e.kind == K_VCMD)
                  chk(cyc - t_pulse >= PUL_C, "R5", "pulse gap", cyc - t_pulse, PUL_C);
               if (e.kind == K_PULSE) t_pulse = cyc;
            end
            bus_rdata = (!bus_we && rd_q.size() > 0) ? rd_q.pop_front() : 16'h0000;
            bus_ack   = 1'b1;
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // sectors: entry0=05, entry1=12, entry2=7F, entry3=00
      sect_list = {7'h00, 7'h7F, 7'h12, 7'h05};

      repeat (3) @(negedge clk);
      chk(busy == 0, "R1", "busy in reset", busy, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(busy == 0 && done == 0 && fail == 0, "R1", "status after reset", {busy, done, fail}, 0);
      chk(hv_req == 0 && bus_req == 0, "R1", "requests after reset", {hv_req, bus_req}, 0);

      // run A: two sectors, second needs two extra pulses (R6, R11)
      sect_cnt = CW'(2);
      push(1'b1, '0, 16'h0060, 1'b1, K_SETUP);
      push_sector(7'h05, 0, 1'b1, 16'h0000);
      push_sector(7'h12, 2, 1'b1, 16'h0000);
      push(1'b1, '0, 16'h00F0, 1'b0, K_RESET);
      pulse_start();
      chk(busy == 1 && hv_req == 1, "R2", "hv_req after start", {busy, hv_req}, 3);
      end_run("R6", 1'b0);

      // run B: sector never locks, value 0003 is not accepted (R6, R7)
      sect_cnt = CW'(3);
      sect_list = {7'h00, 7'h7F, 7'h12, 7'h33};
      push(1'b1, '0, 16'h0060, 1'b1, K_SETUP);
      push_sector(7'h33, MAXP, 1'b0, 16'h0003);
      push(1'b1, '0, 16'h00F0, 1'b0, K_RESET);
      pulse_start();
      end_run("R7", 1'b1);

      // R9: status holds while idle
      repeat (20) @(negedge clk);
      chk(done == 1 && fail == 1, "R9", "status held", {done, fail}, 3);

      // run C: all four sectors, start pulsed while busy (R10); also clears status
      sect_list = {7'h00, 7'h7F, 7'h12, 7'h05};
      sect_cnt = CW'(4);
      push(1'b1, '0, 16'h0060, 1'b1, K_SETUP);
      push_sector(7'h05, 0, 1'b1, 16'h0000);
      push_sector(7'h12, 0, 1'b1, 16'h0000);
      push_sector(7'h7F, 1, 1'b1, 16'h0000);
      push_sector(7'h00, 0, 1'b1, 16'h0000);
      push(1'b1, '0, 16'h00F0, 1'b0, K_RESET);
      pulse_start();
      chk(done == 0 && fail == 0, "R9", "status cleared by start", {done, fail}, 0);
      repeat (60) @(negedge clk);
      pulse_start();
      chk(busy == 1 && done == 0, "R10", "start while busy", {busy, done}, 2);
      end_run("R11", 1'b0);

      // run D: count 0 acts as one sector (R11)
      sect_cnt = CW'(0);
      push(1'b1, '0, 16'h0060, 1'b1, K_SETUP);
      push_sector(7'h05, 0, 1'b1, 16'h0000);
      push(1'b1, '0, 16'h00F0, 1'b0, K_RESET);
      pulse_start();
      end_run("R11", 1'b0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule